// File: doc/BRIEF.md
# Debug Register to AHB Bridge

This block sits behind a debug port and turns its 32-bit register accesses into single transfers on an AHB-Lite master bus. Software on the debug side programs a control word and a target address, then reads or writes a data register to move one byte, halfword or word at that address. An optional post-increment steps the target address by the transfer size, so a run of data-register accesses walks through memory without reprogramming the address.

A 16-byte window of four banked data registers reaches the four words of the aligned block that holds the target address. Banked accesses always move whole words and never touch the target address, so a debugger can poke a small structure with no address writes at all. A read-only register returns the fixed base address of the debug ROM table.

The debug side is a request/response stream. A request is taken on a clock edge where `dbg_req_valid` and `dbg_req_ready` are both high. Every request, read or write, gets exactly one response. `dbg_req_ready` stays low from the accepting edge until the response has been taken. A response is offered with `dbg_rsp_valid` and stays unchanged until an edge where `dbg_rsp_ready` is high. Only one bus transfer is ever in flight.

Top module: `dab_bridge`

## Requirements
- R1: After reset, `dbg_req_ready` is 1, `busy` is 0, `htrans` is IDLE (00), `dbg_rsp_valid` is 0, `hburst` is SINGLE (000), and both the control word and the target address read back as 0.
- R2: Each accepted request yields one response. While `dbg_rsp_valid` is high and `dbg_rsp_ready` is low, the response data and error bit stay unchanged and no new request is accepted.
- R3: Register map, in byte addresses on `dbg_req_addr` (bits 7:2 given): 0x00 control word, 0x04 target address (read/write), 0x0C data register, 0x10/0x14/0x18/0x1C banked data registers, 0xF8 ROM base. Control word fields: size in bits 2:0 (0 byte, 1 halfword, 2 word, codes 3 to 7 act as word), post-increment in bits 5:4 (1 steps the address, any other code leaves it alone), sticky error in bit 8. Reads of any other address return 0 and writes to one change nothing.
- R4: The ROM base register at 0xF8 returns the `ROM_BASE` parameter. A write to it leaves the value it returns unchanged.
- R5: A data-register write issues an AHB write at `haddr` equal to the target address with `hsize` equal to the size field. A byte value is repeated on all four lanes of `hwdata`, and a halfword value on both halves.
- R6: A data-register read issues an AHB read and returns the addressed lanes zero-extended: the byte at address bits 1:0 for a byte read, the halfword chosen by address bit 1 for a halfword read, the whole word otherwise.
- R7: With post-increment set to 1, each data-register access that ends OKAY adds 1, 2 or 4 (per size) to the target address. With any other post-increment code the address is left as it is.
- R8: A banked access at byte address 0x10+4k uses `haddr` = {target address bits 31:4, k, 00} and never changes the target address, whatever the post-increment code.
- R9: Banked transfers always use `hsize` = word (010) with the full 32-bit data, whatever the size field holds.
- R10: Each bus access drives `htrans` NONSEQ (10) for exactly one address phase, held with `haddr` stable while `hready` is low, and IDLE (00) at all other times.
- R11: An ERROR response ends the access with `dbg_rsp_err` = 1, read data 0 and no post-increment, and sets control bit 8. That bit stays set until the control word is written with bit 8 = 1; a write with bit 8 = 0 leaves it set.
- R12: `busy` is high from the edge that accepts a bus access until the edge at which `hready` completes its data phase, and wait states on `hready` stretch this window by one cycle each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dbg_req_valid | input | 1 | Debug request present |
| dbg_req_ready | output | 1 | Bridge can take a request |
| dbg_req_write | input | 1 | 1 for register write, 0 for read |
| dbg_req_addr | input | 6 | Register byte address bits 7:2 |
| dbg_req_wdata | input | 32 | Register write data |
| dbg_rsp_valid | output | 1 | Response present |
| dbg_rsp_ready | input | 1 | Debug side takes the response |
| dbg_rsp_rdata | output | 32 | Read result (0 for writes) |
| dbg_rsp_err | output | 1 | Bus access ended with ERROR |
| busy | output | 1 | Bus transfer in flight |
| haddr | output | ADDR_W | AHB address |
| htrans | output | 2 | AHB transfer type |
| hwrite | output | 1 | AHB write |
| hsize | output | 3 | AHB transfer size |
| hburst | output | 3 | AHB burst type, always SINGLE |
| hwdata | output | 32 | AHB write data |
| hrdata | input | 32 | AHB read data |
| hready | input | 1 | AHB transfer done |
| hresp | input | 1 | AHB error response |

## Verification
The bench builds the bridge with the default 32-bit address and a `ROM_BASE` of 0x8BADF00D, a value no other register holds at any point, so a misdecoded read of 0xF8 cannot pass by accident. The full 32-bit address lets the tests place targets at 0x2000_00xx, so the upper 28 bits that banked accesses keep from the target address are nonzero and visibly carried to `haddr`. Its AHB slave model inserts a chosen number of wait states or a two-cycle ERROR, which brings the `busy` window, the held address phase and the sticky error flag within reach.

// File: rtl/dab_pkg.sv
package dab_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned NLANE = DW / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_RESP} st_e;

  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;
  localparam logic [2:0] HB_SINGLE = 3'b000;

  localparam logic [2:0] SZ_BYTE = 3'd0;
  localparam logic [2:0] SZ_HALF = 3'd1;
  localparam logic [2:0] SZ_WORD = 3'd2;

  // register word indices (byte address bits 7:2)
  localparam logic [5:0] WI_CTRL  = 6'h00;
  localparam logic [5:0] WI_TADDR = 6'h01;
  localparam logic [5:0] WI_DATA  = 6'h03;
  localparam logic [5:0] WI_ROM   = 6'h3E;
  localparam logic [3:0] BANK_HI  = 4'h1;

  localparam logic [1:0] INC_SINGLE = 2'b01;

  typedef struct packed {
    logic       err;
    logic [1:0] incr;
    logic [2:0] size;
  } ctrl_t;

  function automatic logic [2:0] eff_size(input logic [2:0] s);
    return (s > SZ_WORD) ? SZ_WORD : s;
  endfunction
endpackage

// File: rtl/dab_lanes.sv
module dab_lanes
  import dab_pkg::*;
(
  input  logic [2:0]    wr_size,
  input  logic [DW-1:0] wr_val,
  output logic [DW-1:0] wr_rep,
  input  logic [2:0]    rd_size,
  input  logic [1:0]    rd_off,
  input  logic [DW-1:0] bus_val,
  output logic [DW-1:0] rd_val
);
  logic [7:0] lane_b [NLANE];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_b[g] = bus_val[8*g +: 8];
  end

  // write side: copy the narrow value onto every lane it may land on
  always_comb begin
    for (int i = 0; i < NLANE; i++) begin
      case (wr_size)
        SZ_BYTE: wr_rep[8*i +: 8] = wr_val[7:0];
        SZ_HALF: wr_rep[8*i +: 8] = wr_val[8*(i%2) +: 8];
        default: wr_rep[8*i +: 8] = wr_val[8*i +: 8];
      endcase
    end
  end

  // read side: pick the addressed lanes and zero-extend
  always_comb begin
    rd_val = '0;
    case (rd_size)
      SZ_BYTE: rd_val[7:0]  = lane_b[rd_off];
      SZ_HALF: rd_val[15:0] = {lane_b[{rd_off[1], 1'b1}], lane_b[{rd_off[1], 1'b0}]};
      default: rd_val       = bus_val;
    endcase
  end
endmodule

// File: rtl/dab_regs.sv
module dab_regs
  import dab_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_ctrl,
  input  logic              we_taddr,
  input  logic [DW-1:0]     wdata,
  input  logic              done,
  input  logic              done_err,
  input  logic              done_data,
  output ctrl_t             cfg_q,
  output logic [ADDR_W-1:0] taddr_q
);
  logic clear_err;
  logic step;
  logic unused_wbits;

  assign clear_err    = we_ctrl && wdata[8];
  assign step         = done && !done_err && done_data && (cfg_q.incr == INC_SINGLE);
  assign unused_wbits = ^{wdata[DW-1:9], wdata[7:6], wdata[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      taddr_q <= '0;
    end else begin
      if (we_ctrl) begin
        cfg_q.size <= wdata[2:0];
        cfg_q.incr <= wdata[5:4];
      end
      if (done && done_err)  cfg_q.err <= 1'b1;
      else if (clear_err)    cfg_q.err <= 1'b0;

      if (we_taddr)  taddr_q <= wdata[ADDR_W-1:0];
      else if (step) taddr_q <= taddr_q + (ADDR_W'(1) << eff_size(cfg_q.size));
    end
  end

  AST_BANK_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (done && !done_data) |=> $stable(taddr_q)) else $error("banked access moved the target address"); // R8
  AST_NO_STEP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (done && !we_taddr && cfg_q.incr != INC_SINGLE) |=> $stable(taddr_q)) else $error("address stepped with increment off"); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (cfg_q.err && !clear_err) |=> cfg_q.err) else $error("error flag dropped"); // R11
endmodule

// File: rtl/dab_master.sv
module dab_master
  import dab_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_bus,
  input  logic              req_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     reg_rdata,
  input  logic [DW-1:0]     rd_ext,
  output logic              req_ready,
  output logic              busy,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [DW-1:0]     hwdata,
  input  logic              hready,
  input  logic              hresp,
  output logic [2:0]        lat_size,
  output logic [1:0]        lat_off,
  output logic              done,
  output logic              done_err,
  output logic              done_data
);
  st_e  state_q;
  logic data_q;

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q == ST_ADDR) || (state_q == ST_DATA);
  assign rsp_valid = (state_q == ST_RESP);
  assign htrans    = (state_q == ST_ADDR) ? HT_NONSEQ : HT_IDLE;
  assign done      = (state_q == ST_DATA) && hready;
  assign done_err  = hresp;
  assign done_data = data_q;
  assign lat_size  = hsize;
  assign lat_off   = haddr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      data_q    <= 1'b0;
      haddr     <= '0;
      hwrite    <= 1'b0;
      hsize     <= SZ_WORD;
      hwdata    <= '0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          if (req_bus) begin
            haddr   <= bus_addr;
            hwrite  <= req_write;
            hsize   <= bus_size;
            hwdata  <= bus_wdata;
            data_q  <= req_data;
            state_q <= ST_ADDR;
          end else begin
            rsp_rdata <= req_write ? '0 : reg_rdata;
            rsp_err   <= 1'b0;
            state_q   <= ST_RESP;
          end
        end
        ST_ADDR: if (hready) state_q <= ST_DATA;
        ST_DATA: if (hready) begin
          rsp_err   <= hresp;
          rsp_rdata <= (hwrite || hresp) ? '0 : rd_ext;
          state_q   <= ST_RESP;
        end
        default: if (rsp_ready) state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ADDR_PHASE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (htrans == HT_NONSEQ && !hready) |=> (htrans == HT_NONSEQ && $stable(haddr))) else $error("address phase not held"); // R10
  AST_SINGLE_NONSEQ: assert property (@(posedge clk) disable iff (!rst_n) (htrans == HT_NONSEQ && hready) |=> (htrans == HT_IDLE)) else $error("second address phase issued"); // R10
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))) else $error("response changed under back-pressure"); // R2
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (busy && !hready) |=> busy) else $error("busy dropped during wait state"); // R12
endmodule

// File: rtl/dab_bridge.sv
module dab_bridge
  import dab_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [31:0] ROM_BASE = 32'h1000_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_req_valid,
  output logic              dbg_req_ready,
  input  logic              dbg_req_write,
  input  logic [7:2]        dbg_req_addr,
  input  logic [31:0]       dbg_req_wdata,
  output logic              dbg_rsp_valid,
  input  logic              dbg_rsp_ready,
  output logic [31:0]       dbg_rsp_rdata,
  output logic              dbg_rsp_err,
  output logic              busy,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [31:0]       hwdata,
  input  logic [31:0]       hrdata,
  input  logic              hready,
  input  logic              hresp
);
  ctrl_t             cfg_q;
  logic [ADDR_W-1:0] taddr_q;
  logic              fire, is_bank, is_data, is_bus;
  logic [ADDR_W-1:0] bus_addr;
  logic [2:0]        bus_size, lat_size;
  logic [1:0]        lat_off;
  logic [DW-1:0]     bus_wdata, rd_ext, reg_rdata;
  logic              done, done_err, done_data;

  assign hburst   = HB_SINGLE;
  assign fire     = dbg_req_valid && dbg_req_ready;
  assign is_bank  = (dbg_req_addr[7:4] == BANK_HI);
  assign is_data  = (dbg_req_addr == WI_DATA);
  assign is_bus   = is_bank || is_data;
  assign bus_addr = is_bank ? {taddr_q[ADDR_W-1:4], dbg_req_addr[3:2], 2'b00} : taddr_q;
  assign bus_size = is_bank ? SZ_WORD : eff_size(cfg_q.size);

  always_comb begin
    reg_rdata = '0;
    case (dbg_req_addr)
      WI_CTRL: begin
        reg_rdata[2:0] = cfg_q.size;
        reg_rdata[5:4] = cfg_q.incr;
        reg_rdata[8]   = cfg_q.err;
      end
      WI_TADDR: reg_rdata[ADDR_W-1:0] = taddr_q;
      WI_ROM:   reg_rdata = ROM_BASE;
      default:  reg_rdata = '0;
    endcase
  end

  dab_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_ctrl   (fire && dbg_req_write && dbg_req_addr == WI_CTRL),
    .we_taddr  (fire && dbg_req_write && dbg_req_addr == WI_TADDR),
    .wdata     (dbg_req_wdata),
    .done      (done),
    .done_err  (done_err),
    .done_data (done_data),
    .cfg_q     (cfg_q),
    .taddr_q   (taddr_q)
  );

  dab_lanes u_lanes (
    .wr_size (bus_size),
    .wr_val  (dbg_req_wdata),
    .wr_rep  (bus_wdata),
    .rd_size (lat_size),
    .rd_off  (lat_off),
    .bus_val (hrdata),
    .rd_val  (rd_ext)
  );

  dab_master #(.ADDR_W(ADDR_W)) u_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (dbg_req_valid),
    .req_write (dbg_req_write),
    .req_bus   (is_bus),
    .req_data  (is_data),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .reg_rdata (reg_rdata),
    .rd_ext    (rd_ext),
    .req_ready (dbg_req_ready),
    .busy      (busy),
    .rsp_ready (dbg_rsp_ready),
    .rsp_valid (dbg_rsp_valid),
    .rsp_rdata (dbg_rsp_rdata),
    .rsp_err   (dbg_rsp_err),
    .haddr     (haddr),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .hsize     (hsize),
    .hwdata    (hwdata),
    .hready    (hready),
    .hresp     (hresp),
    .lat_size  (lat_size),
    .lat_off   (lat_off),
    .done      (done),
    .done_err  (done_err),
    .done_data (done_data)
  );

  AST_BANK_ADDR_WORD: assert property (@(posedge clk) disable iff (!rst_n) (fire && is_bank) |=> (htrans == HT_NONSEQ && hsize == SZ_WORD && haddr[3:0] == {$past(dbg_req_addr[3:2]), 2'b00} && haddr[ADDR_W-1:4] == $past(taddr_q[ADDR_W-1:4]))) else $error("banked transfer mis-formed"); // R9
  AST_DATA_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (fire && is_data) |=> (htrans == HT_NONSEQ && haddr == $past(taddr_q))) else $error("data transfer address wrong"); // R5
  AST_ACCEPT_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (busy || dbg_rsp_valid) |-> !dbg_req_ready) else $error("request accepted while occupied"); // R2
endmodule

// File: tb/sim_dab_bridge.sv
module sim_dab_bridge;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] ROM_VAL    = 32'h8BAD_F00D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_req_valid = 1'b0, dbg_req_write = 1'b0, dbg_rsp_ready = 1'b0;
  logic [7:2]  dbg_req_addr = '0;
  logic [31:0] dbg_req_wdata = '0;
  logic        dbg_req_ready, dbg_rsp_valid, dbg_rsp_err, busy, hwrite;
  logic [31:0] dbg_rsp_rdata, haddr, hwdata;
  logic [1:0]  htrans;
  logic [2:0]  hsize, hburst;
  logic [31:0] hrdata = '0;
  logic        hready = 1'b1, hresp = 1'b0;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dab_bridge #(.ADDR_W(32), .ROM_BASE(ROM_VAL)) u0 (
    .clk(clk), .rst_n(rst_n),
    .dbg_req_valid(dbg_req_valid), .dbg_req_ready(dbg_req_ready), .dbg_req_write(dbg_req_write),
    .dbg_req_addr(dbg_req_addr), .dbg_req_wdata(dbg_req_wdata),
    .dbg_rsp_valid(dbg_rsp_valid), .dbg_rsp_ready(dbg_rsp_ready), .dbg_rsp_rdata(dbg_rsp_rdata),
    .dbg_rsp_err(dbg_rsp_err), .busy(busy),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
    .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  // ---------------- AHB slave model ----------------
  logic [31:0] mem [16];
  int          cfg_waits = 0;
  logic        cfg_err = 1'b0;
  logic        dp_live = 1'b0, dp_write = 1'b0, dp_err = 1'b0, err_half = 1'b0;
  logic [31:0] dp_addr = '0;
  logic [2:0]  dp_size = '0;
  int          waits_left = 0;
  logic [31:0] last_haddr = '0, last_hwdata = '0;
  logic [2:0]  last_hsize = '0;
  logic        last_hwrite = 1'b0;
  int          nonseq_cnt = 0;

  always @(posedge clk) begin
    if (hready) begin
      if (dp_live) begin
        if (dp_write && !dp_err) begin
          for (int b = 0; b < 4; b++) begin
            logic hit;
            case (dp_size)
              3'd0:    hit = (b == int'(dp_addr[1:0]));
              3'd1:    hit = ((b / 2) == int'(dp_addr[1]));
              default: hit = 1'b1;
            endcase
            if (hit) mem[dp_addr[5:2]][8*b +: 8] = hwdata[8*b +: 8];
          end
        end
        if (dp_write) last_hwdata = hwdata;
        dp_live = 1'b0;
      end
      if (htrans == 2'b10) begin
        dp_live     = 1'b1;
        dp_addr     = haddr;
        dp_write    = hwrite;
        dp_size     = hsize;
        dp_err      = cfg_err;
        err_half    = 1'b0;
        waits_left  = cfg_waits;
        last_haddr  = haddr;
        last_hsize  = hsize;
        last_hwrite = hwrite;
        nonseq_cnt  = nonseq_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!dp_live) begin
      hready = 1'b1; hresp = 1'b0;
    end else if (waits_left > 0) begin
      hready = 1'b0; hresp = 1'b0; waits_left = waits_left - 1;
    end else if (dp_err && !err_half) begin
      hready = 1'b0; hresp = 1'b1; err_half = 1'b1;
    end else begin
      hready = 1'b1; hresp = dp_err;
      hrdata = dp_err ? 32'hDEAD_DEAD : mem[dp_addr[5:2]];
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  int busy_cnt;

  task automatic dbg_xfer(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                          input int hold, output logic [31:0] rd, output logic er);
    @(negedge clk);
    dbg_req_valid = 1'b1; dbg_req_write = wr; dbg_req_addr = a[7:2]; dbg_req_wdata = wd;
    while (!dbg_req_ready) @(negedge clk);
    @(negedge clk);
    dbg_req_valid = 1'b0;
    busy_cnt = 0;
    while (!dbg_rsp_valid) begin
      if (busy && !dbg_req_ready) busy_cnt++;
      @(negedge clk);
    end
    rd = dbg_rsp_rdata; er = dbg_rsp_err;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R2 rsp_valid held", {31'b0, dbg_rsp_valid}, 32'd1);
      chk("R2 rsp data held", dbg_rsp_rdata, rd);
      chk("R2 no accept while pending", {31'b0, dbg_req_ready}, 32'd0);
    end
    dbg_rsp_ready = 1'b1;
    @(negedge clk);
    dbg_rsp_ready = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r; logic e;
    dbg_xfer(1'b1, a, d, 0, r, e);
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    logic e;
    dbg_xfer(1'b0, a, 32'h0, 0, d, e);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    logic [31:0] r;
    chk("R1 req_ready", {31'b0, dbg_req_ready}, 32'd1);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 htrans idle", {30'b0, htrans}, 32'd0);
    chk("R1 rsp_valid", {31'b0, dbg_rsp_valid}, 32'd0);
    chk("R1 hburst single", {29'b0, hburst}, 32'd0);
    rd_reg(8'h00, r); chk("R1 ctrl reset", r, 32'h0);
    rd_reg(8'h04, r); chk("R1 taddr reset", r, 32'h0);
  endtask

  task automatic t_rom_map;
    logic [31:0] r;
    int n0;
    n0 = nonseq_cnt;
    rd_reg(8'hF8, r); chk("R4 rom base", r, ROM_VAL);
    wr_reg(8'hF8, 32'h1234_5678);
    rd_reg(8'hF8, r); chk("R4 rom write ignored", r, ROM_VAL);
    wr_reg(8'h40, 32'hFFFF_FFFF);
    rd_reg(8'h40, r); chk("R3 unmapped reads zero", r, 32'h0);
    rd_reg(8'h00, r); chk("R3 unmapped write no effect ctrl", r, 32'h0);
    chk("R3 register access stays off bus", nonseq_cnt - n0, 0);
    wr_reg(8'h00, 32'h0000_0012);
    rd_reg(8'h00, r); chk("R3 ctrl readback", r, 32'h12);
    wr_reg(8'h04, 32'h1234_5678);
    rd_reg(8'h04, r); chk("R3 taddr readback", r, 32'h1234_5678);
  endtask

  task automatic t_data_word;
    logic [31:0] r;
    wr_reg(8'h00, 32'h02);
    wr_reg(8'h04, 32'h2000_0008);
    wr_reg(8'h0C, 32'hCAFE_BABE);
    chk("R5 write haddr", last_haddr, 32'h2000_0008);
    chk("R5 write hsize", {29'b0, last_hsize}, 32'd2);
    chk("R5 write hwrite", {31'b0, last_hwrite}, 32'd1);
    chk("R5 write hwdata", last_hwdata, 32'hCAFE_BABE);
    rd_reg(8'h04, r); chk("R7 no step when off", r, 32'h2000_0008);
    rd_reg(8'h0C, r); chk("R6 word read", r, 32'hCAFE_BABE);
    chk("R6 read hwrite low", {31'b0, last_hwrite}, 32'd0);
  endtask

  task automatic t_narrow;
    logic [31:0] r;
    mem[1] = 32'h1122_3344;
    wr_reg(8'h00, 32'h00);
    wr_reg(8'h04, 32'h2000_0005);
    wr_reg(8'h0C, 32'h0000_00A5);
    chk("R5 byte replicate", last_hwdata, 32'hA5A5_A5A5);
    chk("R5 byte hsize", {29'b0, last_hsize}, 32'd0);
    chk("R5 byte landed", mem[1], 32'h1122_A544);
    rd_reg(8'h0C, r); chk("R6 byte lane read", r, 32'h0000_00A5);
    wr_reg(8'h00, 32'h01);
    wr_reg(8'h04, 32'h2000_000A);
    rd_reg(8'h0C, r); chk("R6 upper half read", r, 32'h0000_CAFE);
    wr_reg(8'h0C, 32'h0000_1357);
    chk("R5 half replicate", last_hwdata, 32'h1357_1357);
    chk("R5 half landed", mem[2], 32'h1357_BABE);
  endtask

  task automatic t_incr;
    logic [31:0] r;
    wr_reg(8'h00, 32'h12);
    wr_reg(8'h04, 32'h2000_0010);
    wr_reg(8'h0C, 32'h1);
    chk("R7 first step addr", last_haddr, 32'h2000_0010);
    wr_reg(8'h0C, 32'h2);
    chk("R7 second step addr", last_haddr, 32'h2000_0014);
    rd_reg(8'h04, r); chk("R7 word step", r, 32'h2000_0018);
    wr_reg(8'h00, 32'h10);
    rd_reg(8'h0C, r);
    rd_reg(8'h04, r); chk("R7 byte step", r, 32'h2000_0019);
    wr_reg(8'h00, 32'h11);
    wr_reg(8'h04, 32'h2000_0020);
    rd_reg(8'h0C, r);
    rd_reg(8'h04, r); chk("R7 half step", r, 32'h2000_0022);
    wr_reg(8'h00, 32'h32);
    wr_reg(8'h04, 32'h2000_0020);
    rd_reg(8'h0C, r);
    rd_reg(8'h04, r); chk("R7 code 3 no step", r, 32'h2000_0020);
  endtask

  task automatic t_banked;
    logic [31:0] r;
    mem[12] = 32'h0BAD_C0DE;
    wr_reg(8'h00, 32'h10);
    wr_reg(8'h04, 32'h2000_0034);
    wr_reg(8'h18, 32'h55AA_55AA);
    chk("R8 bank2 haddr", last_haddr, 32'h2000_0038);
    chk("R9 bank write word size", {29'b0, last_hsize}, 32'd2);
    chk("R9 bank write full data", last_hwdata, 32'h55AA_55AA);
    rd_reg(8'h10, r);
    chk("R8 bank0 haddr", last_haddr, 32'h2000_0030);
    chk("R9 bank read full word", r, 32'h0BAD_C0DE);
    rd_reg(8'h04, r); chk("R8 taddr untouched", r, 32'h2000_0034);
  endtask

  task automatic t_waits;
    logic [31:0] r; logic e;
    int n0;
    wr_reg(8'h00, 32'h02);
    wr_reg(8'h04, 32'h2000_0030);
    cfg_waits = 3;
    n0 = nonseq_cnt;
    dbg_xfer(1'b0, 8'h0C, 32'h0, 0, r, e);
    cfg_waits = 0;
    chk("R12 busy window with 3 waits", busy_cnt, 5);
    chk("R12 data after waits", r, 32'h0BAD_C0DE);
    chk("R10 one address phase", nonseq_cnt - n0, 1);
    dbg_xfer(1'b0, 8'h0C, 32'h0, 0, r, e);
    chk("R12 busy window no waits", busy_cnt, 2);
  endtask

  task automatic t_backpressure;
    logic [31:0] r; logic e;
    dbg_xfer(1'b0, 8'h04, 32'h0, 3, r, e);
    chk("R2 held response value", r, 32'h2000_0030);
  endtask

  task automatic t_error;
    logic [31:0] r; logic e;
    wr_reg(8'h00, 32'h12);
    wr_reg(8'h04, 32'h2000_0000);
    cfg_err = 1'b1;
    dbg_xfer(1'b0, 8'h0C, 32'h0, 0, r, e);
    cfg_err = 1'b0;
    chk("R11 rsp_err", {31'b0, e}, 32'd1);
    chk("R11 read data zero", r, 32'h0);
    rd_reg(8'h04, r); chk("R11 no step on error", r, 32'h2000_0000);
    rd_reg(8'h00, r); chk("R11 sticky set", r, 32'h112);
    wr_reg(8'h00, 32'h012);
    rd_reg(8'h00, r); chk("R11 write 0 keeps flag", r, 32'h112);
    dbg_xfer(1'b0, 8'h0C, 32'h0, 0, r, e);
    chk("R11 later OK response", {31'b0, e}, 32'd0);
    wr_reg(8'h00, 32'h112);
    rd_reg(8'h00, r); chk("R11 write 1 clears", r, 32'h012);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rom_map();
    t_data_word();
    t_narrow();
    t_incr();
    t_banked();
    t_waits();
    t_backpressure();
    t_error();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule